// File: doc/BRIEF.md
# Infrared Mark and Period Capture Receiver

This receiver watches a demodulated remote-control input and times every symbol in units of a divided sample tick. For each symbol it records two numbers: how long the carrier stayed present (the mark) and how long it was from that mark's leading edge to the leading edge of the following mark (the period). Each pair goes into a small capture FIFO. Software drains the FIFO over a simple register bus, and an interrupt line reports new data, the end of a train, FIFO full and overrun.

The input first passes through a two-flop synchroniser and an optional inverter, because the pin idles at the carrier-present level of the opposite polarity. A symmetric glitch filter then drops pulses shorter than a programmable number of ticks. If the input stays idle until the running period reaches the programmed maximum, the open symbol is closed with an all-ones period. That sentinel marks the last symbol of a train.

Bus registers, by word address on `bus_addr`: 0 control (bit 0 capture enable, bit 1 input invert), 1 tick divisor, 2 maximum period, 3 glitch length, 4 interrupt enable, 5 interrupt pending (write ones to clear), 6 status, 7 held mark, 8 period (reading it pops the FIFO). A read strobe returns data on `bus_rdata` in the cycle after the strobe. Interrupt bit positions, used in both enable and pending: bit 0 new entry, bit 1 end of train, bit 2 overrun, bit 3 FIFO became full.

Top module: `ir_capture_rx`

## Requirements
- R1: After reset: control reads 0, divisor reads 1, maximum period reads 0x5000, glitch length reads 1, status and pending read 0, and `irq` is low.
- R2: With divisor 1, an active input lasting H clocks followed by an idle gap of L clocks produces one entry with mark H and period H+L.
- R3: The sample tick runs once every D clocks for a divisor D (0 acts as 1), so the captured times scale down by D.
- R4: Control bit 1 set makes a low pin the active (mark) level. Control bit 1 clear makes a high pin active.
- R5: An active or idle excursion shorter than the glitch length in ticks is ignored: it neither starts a symbol nor splits one, and the period keeps counting through it.
- R6: If no new mark starts before the running period reaches the maximum period, the entry is pushed with period 0xFFFF and pending bit 1 is set.
- R7: Reading address 8 returns the oldest entry's period and pops it. Address 7 then returns that entry's mark until the next pop. Status bits 15:8 hold the FIFO fill count.
- R8: The FIFO holds 8 entries. An entry arriving when it is full is dropped and sets pending bit 2, which status bit 2 mirrors. The push that fills the FIFO sets pending bit 3, and the stored entries are left untouched.
- R9: Writing ones to address 5 clears exactly those pending bits. Zero bits leave pending bits as they were.
- R10: `irq` is high, one cycle after the change, whenever any pending bit has its enable bit set, and low otherwise.
- R11: With control bit 0 clear, no entries are captured and no pending bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid the cycle after `bus_rd` |
| rx_pin | input | 1 | Demodulated receiver input, asynchronous |
| irq | output | 1 | Level interrupt request |

## Verification
The bench uses a train whose last symbol ends in a timeout. A design that lost the sentinel, or counted the period from the falling edge, would return a wrong second number. A two-tick glitch is placed inside a gap while the glitch length is four. A filter that let it through would split the symbol into two short entries. Ten symbols are pushed into the eight-entry FIFO. A design that overwrote on overrun, or failed to flag it, would show corrupted early entries or a clear overrun bit. The bench also clears a single pending bit and checks that the others survive, and runs a capture with the enable clear. A sloppy clear mask or a leaky enable shows up there.

// File: rtl/ir_cap_pkg.sv
package ir_cap_pkg;
  localparam int CNT_W = 16;

  localparam logic [3:0] A_CTRL   = 4'd0;
  localparam logic [3:0] A_DIV    = 4'd1;
  localparam logic [3:0] A_MAXPER = 4'd2;
  localparam logic [3:0] A_NOISE  = 4'd3;
  localparam logic [3:0] A_INTEN  = 4'd4;
  localparam logic [3:0] A_PEND   = 4'd5;
  localparam logic [3:0] A_STAT   = 4'd6;
  localparam logic [3:0] A_MARK   = 4'd7;
  localparam logic [3:0] A_PER    = 4'd8;

  typedef struct packed {
    logic [CNT_W-1:0] mark;
    logic [CNT_W-1:0] period;
  } sym_t;

  typedef enum logic [1:0] {ST_IDLE, ST_MARK, ST_SPACE} meas_st_t;
endpackage

// File: rtl/ir_input_cond.sv
module ir_input_cond #(
  parameter int NW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rx_pin,
  input  logic          invert,
  input  logic          tick,
  input  logic [NW-1:0] noise,
  output logic          filt
);
  logic          s1, s2, raw;
  logic [NW-1:0] cnt;
  logic [NW:0]   nxt, thr;

  assign raw = s2 ^ invert;
  assign nxt = {1'b0, cnt} + (NW+1)'(1);
  assign thr = (noise == '0) ? (NW+1)'(1) : {1'b0, noise};

  always_ff @(posedge clk) begin
    if (rst) begin
      s1   <= 1'b0;
      s2   <= 1'b0;
      cnt  <= '0;
      filt <= 1'b0;
    end else begin
      s1 <= rx_pin;
      s2 <= s1;
      if (tick) begin
        if (raw != filt) begin
          if (nxt >= thr) begin
            filt <= raw;
            cnt  <= '0;
          end else begin
            cnt <= nxt[NW-1:0];
          end
        end else begin
          cnt <= '0;
        end
      end
    end
  end

  // R5: the filtered level moves only on a sample tick
  assert_filt_on_tick_R5: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(filt));
endmodule

// File: rtl/ir_sym_meas.sv
module ir_sym_meas
  import ir_cap_pkg::*;
#(
  parameter int CW = CNT_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          tick,
  input  logic          filt,
  input  logic [CW-1:0] max_per,
  output logic          push,
  output logic          push_last,
  output logic [CW-1:0] push_mark,
  output logic [CW-1:0] push_per
);
  localparam logic [CW-1:0] SAT  = {CW{1'b1}} - CW'(1);
  localparam logic [CW-1:0] ONES = {CW{1'b1}};

  meas_st_t      st;
  logic [CW-1:0] mark_c, per_c;

  function automatic logic [CW-1:0] inc_sat(input logic [CW-1:0] v);
    return (v >= SAT) ? SAT : v + CW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      st        <= ST_IDLE;
      mark_c    <= '0;
      per_c     <= '0;
      push      <= 1'b0;
      push_last <= 1'b0;
      push_mark <= '0;
      push_per  <= '0;
    end else begin
      push <= 1'b0;
      if (tick) begin
        case (st)
          ST_IDLE: if (filt) begin
            st     <= ST_MARK;
            mark_c <= CW'(1);
            per_c  <= CW'(1);
          end
          ST_MARK: begin
            per_c <= inc_sat(per_c);
            if (filt) mark_c <= inc_sat(mark_c);
            else      st     <= ST_SPACE;
          end
          default: begin
            if (filt) begin
              push      <= 1'b1;
              push_last <= 1'b0;
              push_mark <= mark_c;
              push_per  <= per_c;
              mark_c    <= CW'(1);
              per_c     <= CW'(1);
              st        <= ST_MARK;
            end else if (per_c >= max_per) begin
              push      <= 1'b1;
              push_last <= 1'b1;
              push_mark <= mark_c;
              push_per  <= ONES;
              st        <= ST_IDLE;
            end else begin
              per_c <= inc_sat(per_c);
            end
          end
        endcase
      end
    end
  end

  // R11: a disabled receiver produces no entries
  assert_gate_R11: assert property (@(posedge clk) disable iff (rst)
    !en |=> !push);
endmodule

// File: rtl/ir_cap_fifo.sv
module ir_cap_fifo #(
  parameter int DEPTH = 8,
  parameter int W     = 32,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic [AW:0]  count,
  output logic         full,
  output logic         empty
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          do_push, do_pop;

  assign full    = (count == (AW+1)'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rd_ptr];

  function automatic logic [AW-1:0] nxt_ptr(input logic [AW-1:0] p);
    return (p == AW'(DEPTH-1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= nxt_ptr(wr_ptr);
      if (do_pop)  rd_ptr <= nxt_ptr(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + (AW+1)'(1);
        2'b01:   count <= count - (AW+1)'(1);
        default: count <= count;
      endcase
    end
  end

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
    count <= (AW+1)'(DEPTH));
  assert_drop_when_full_R8: assert property (@(posedge clk) disable iff (rst)
    (push && full && !pop) |=> (count == $past(count)));
endmodule

// File: rtl/ir_capture_rx.sv
module ir_capture_rx
  import ir_cap_pkg::*;
#(
  parameter int          FIFO_DEPTH = 8,
  parameter int          DIV_W      = 16,
  parameter int          NOISE_W    = 8,
  parameter logic [15:0] RST_MAXPER = 16'h5000,
  parameter int          RST_DIV    = 1,
  parameter int          RST_NOISE  = 1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [3:0]  bus_addr,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  input  logic        rx_pin,
  output logic        irq
);
  localparam int FAW = (FIFO_DEPTH > 1) ? $clog2(FIFO_DEPTH) : 1;
  localparam int SW  = $bits(sym_t);

  logic [1:0]         ctrl;
  logic [DIV_W-1:0]   div_r, div_cnt, div_lim;
  logic [CNT_W-1:0]   maxper;
  logic [NOISE_W-1:0] noise_r;
  logic [3:0]         inten, pend, set_v, clr_v;
  logic [CNT_W-1:0]   mark_hold;
  logic               tick, filt;
  logic               m_push, m_last;
  logic [CNT_W-1:0]   m_mark, m_per;
  sym_t               f_din, f_dout;
  logic [FAW:0]       f_count;
  logic               f_full, f_empty, f_pop;

  // sample tick
  assign div_lim = (div_r == '0) ? '0 : div_r - DIV_W'(1);
  always_ff @(posedge clk) begin
    if (rst || !ctrl[0]) begin
      div_cnt <= '0;
      tick    <= 1'b0;
    end else if (div_cnt >= div_lim) begin
      div_cnt <= '0;
      tick    <= 1'b1;
    end else begin
      div_cnt <= div_cnt + DIV_W'(1);
      tick    <= 1'b0;
    end
  end

  ir_input_cond #(.NW(NOISE_W)) u_cond (
    .clk(clk), .rst(rst), .rx_pin(rx_pin), .invert(ctrl[1]),
    .tick(tick), .noise(noise_r), .filt(filt)
  );

  ir_sym_meas #(.CW(CNT_W)) u_meas (
    .clk(clk), .rst(rst), .en(ctrl[0]), .tick(tick), .filt(filt),
    .max_per(maxper), .push(m_push), .push_last(m_last),
    .push_mark(m_mark), .push_per(m_per)
  );

  assign f_din = '{mark: m_mark, period: m_per};
  assign f_pop = bus_rd && (bus_addr == A_PER) && !f_empty;

  ir_cap_fifo #(.DEPTH(FIFO_DEPTH), .W(SW)) u_fifo (
    .clk(clk), .rst(rst), .push(m_push), .din(f_din), .pop(f_pop),
    .dout(f_dout), .count(f_count), .full(f_full), .empty(f_empty)
  );

  // interrupt sources
  always_comb begin
    set_v[0] = m_push && !f_full;
    set_v[1] = m_push && !f_full && m_last;
    set_v[2] = m_push && f_full;
    set_v[3] = m_push && !f_full && !f_pop &&
               (f_count == (FAW+1)'(FIFO_DEPTH - 1));
    clr_v    = (bus_wr && bus_addr == A_PEND) ? bus_wdata[3:0] : 4'd0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl      <= '0;
      div_r     <= DIV_W'(RST_DIV);
      maxper    <= RST_MAXPER;
      noise_r   <= NOISE_W'(RST_NOISE);
      inten     <= '0;
      pend      <= '0;
      mark_hold <= '0;
      bus_rdata <= '0;
      irq       <= 1'b0;
    end else begin
      pend <= (pend & ~clr_v) | set_v;
      irq  <= |(pend & inten);
      if (bus_wr) begin
        case (bus_addr)
          A_CTRL:   ctrl    <= bus_wdata[1:0];
          A_DIV:    div_r   <= bus_wdata[DIV_W-1:0];
          A_MAXPER: maxper  <= bus_wdata;
          A_NOISE:  noise_r <= bus_wdata[NOISE_W-1:0];
          A_INTEN:  inten   <= bus_wdata[3:0];
          default:  ;
        endcase
      end
      if (f_pop) mark_hold <= f_dout.mark;
      if (bus_rd) begin
        case (bus_addr)
          A_CTRL:   bus_rdata <= {14'd0, ctrl};
          A_DIV:    bus_rdata <= 16'(div_r);
          A_MAXPER: bus_rdata <= maxper;
          A_NOISE:  bus_rdata <= 16'(noise_r);
          A_INTEN:  bus_rdata <= {12'd0, inten};
          A_PEND:   bus_rdata <= {12'd0, pend};
          A_STAT:   bus_rdata <= {8'(f_count), 5'd0, pend[2], 2'd0};
          A_MARK:   bus_rdata <= mark_hold;
          A_PER:    bus_rdata <= f_empty ? 16'd0 : f_dout.period;
          default:  bus_rdata <= 16'd0;
        endcase
      end
    end
  end

  assert_w1c_R9: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == A_PEND && bus_wdata[2] && !set_v[2]) |=> !pend[2]);
  assert_irq_needs_enable_R10: assert property (@(posedge clk) disable iff (rst)
    (inten == 4'd0) |=> !irq);
endmodule

// File: tb/test_ir_capture_rx.sv
module test_ir_capture_rx;
  logic        clk = 1'b0;
  logic        rst;
  logic        bus_wr, bus_rd;
  logic [3:0]  bus_addr;
  logic [15:0] bus_wdata, bus_rdata;
  logic        rx_pin;
  logic        irq;
  logic        act_lvl;
  int          n_cmp = 0;
  int          n_bad = 0;
  bit          done  = 1'b0;

  always #4 clk = ~clk;

  ir_capture_rx i_ir_capture_rx (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rx_pin(rx_pin), .irq(irq)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%04h expected 0x%04h", req, act, exp);
    end
  endtask

  task automatic chk_rng(input string req, input logic [15:0] act, input int lo, input int hi);
    n_cmp++;
    if (int'(act) < lo || int'(act) > hi) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic do_reset(input logic idle);
    @(negedge clk);
    rst = 1'b1; bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_wdata = '0;
    rx_pin = idle;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic sym(input int m, input int s);
    @(negedge clk);
    rx_pin = act_lvl;
    repeat (m) @(negedge clk);
    rx_pin = ~act_lvl;
    repeat (s - 1) @(negedge clk);
  endtask

  task automatic pop_chk(input string req, input logic [15:0] em, input logic [15:0] ep);
    logic [15:0] v;
    rd(4'd8, v); chk({req, " period"}, v, ep);
    rd(4'd7, v); chk({req, " mark"}, v, em);
  endtask

  task automatic t_reset;
    logic [15:0] v;
    do_reset(1'b1);
    rd(4'd0, v); chk("R1 ctrl", v, 16'h0);
    rd(4'd1, v); chk("R1 div", v, 16'h1);
    rd(4'd2, v); chk("R1 maxper", v, 16'h5000);
    rd(4'd3, v); chk("R1 noise", v, 16'h1);
    rd(4'd6, v); chk("R1 status", v, 16'h0);
    rd(4'd5, v); chk("R1 pending", v, 16'h0);
    chk("R1 irq", {15'd0, irq}, 16'h0);
  endtask

  task automatic t_basic;
    logic [15:0] v;
    do_reset(1'b1); act_lvl = 1'b0;
    wr(4'd2, 16'd200);
    wr(4'd0, 16'h3);
    sym(10, 25); sym(12, 30); sym(5, 10);
    repeat (300) @(negedge clk);
    rd(4'd6, v); chk("R7 status count", v, 16'h0300);
    rd(4'd5, v); chk("R6 pending last+data", v, 16'h0003);
    pop_chk("R2 first", 16'd10, 16'd35);
    rd(4'd7, v); chk("R7 mark held", v, 16'd10);
    pop_chk("R2 second", 16'd12, 16'd42);
    pop_chk("R6 sentinel", 16'd5, 16'hFFFF);
    rd(4'd6, v); chk("R7 drained", v, 16'h0000);
  endtask

  task automatic t_divider;
    logic [15:0] v;
    do_reset(1'b1); act_lvl = 1'b0;
    wr(4'd1, 16'd4);
    wr(4'd2, 16'd100);
    wr(4'd0, 16'h3);
    sym(40, 60); sym(40, 10);
    repeat (600) @(negedge clk);
    rd(4'd8, v); chk_rng("R3 period/4", v, 24, 26);
    rd(4'd7, v); chk_rng("R3 mark/4", v, 9, 11);
  endtask

  task automatic t_invert;
    do_reset(1'b0); act_lvl = 1'b1;
    wr(4'd2, 16'd40);
    wr(4'd0, 16'h1);
    sym(7, 13); sym(7, 5);
    repeat (80) @(negedge clk);
    pop_chk("R4 high active", 16'd7, 16'd20);
    pop_chk("R4 high active end", 16'd7, 16'hFFFF);
  endtask

  task automatic t_noise;
    logic [15:0] v;
    do_reset(1'b1); act_lvl = 1'b0;
    wr(4'd2, 16'd60);
    wr(4'd3, 16'd4);
    wr(4'd0, 16'h3);
    sym(10, 8); sym(2, 10); sym(10, 5);
    repeat (120) @(negedge clk);
    rd(4'd6, v); chk("R5 glitch ignored count", v, 16'h0200);
    pop_chk("R5 spans glitch", 16'd10, 16'd30);
  endtask

  task automatic t_overrun;
    logic [15:0] v;
    do_reset(1'b1); act_lvl = 1'b0;
    wr(4'd2, 16'd40);
    wr(4'd0, 16'h3);
    for (int i = 0; i < 10; i++) sym(4, 6);
    repeat (80) @(negedge clk);
    rd(4'd6, v); chk("R8 full with overflow", v, 16'h0804);
    rd(4'd5, v); chk("R8 pending", v, 16'h000D);
    wr(4'd5, 16'h0004);
    rd(4'd5, v); chk("R9 only bit2 cleared", v, 16'h0009);
    rd(4'd6, v); chk("R9 status overflow clear", v, 16'h0800);
    for (int i = 0; i < 8; i++) pop_chk("R8 kept entry", 16'd4, 16'd10);
  endtask

  task automatic t_irq;
    logic [15:0] v;
    do_reset(1'b1); act_lvl = 1'b0;
    wr(4'd2, 16'd30);
    wr(4'd0, 16'h3);
    sym(6, 10); sym(6, 5);
    repeat (60) @(negedge clk);
    chk("R10 irq masked", {15'd0, irq}, 16'h0);
    wr(4'd4, 16'h0002);
    @(negedge clk);
    chk("R10 irq on last", {15'd0, irq}, 16'h1);
    wr(4'd5, 16'h0002);
    @(negedge clk);
    chk("R10 irq after clear", {15'd0, irq}, 16'h0);
    rd(4'd5, v); chk("R9 data bit kept", v, 16'h0001);
    wr(4'd4, 16'h0001);
    @(negedge clk);
    chk("R10 irq on data", {15'd0, irq}, 16'h1);
  endtask

  task automatic t_disable;
    logic [15:0] v;
    do_reset(1'b1); act_lvl = 1'b0;
    wr(4'd2, 16'd50);
    wr(4'd0, 16'h2);
    sym(6, 10); sym(6, 10); sym(6, 10);
    repeat (80) @(negedge clk);
    rd(4'd6, v); chk("R11 nothing captured", v, 16'h0);
    rd(4'd5, v); chk("R11 nothing pending", v, 16'h0);
    wr(4'd0, 16'h3);
    sym(6, 10); sym(6, 10);
    repeat (80) @(negedge clk);
    rd(4'd6, v); chk("R11 capture after enable", v, 16'h0200);
    pop_chk("R11 entry", 16'd6, 16'd16);
  endtask

  initial begin
    rst = 1'b1; bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_wdata = '0;
    rx_pin = 1'b1; act_lvl = 1'b0;
    t_reset;
    t_basic;
    t_divider;
    t_invert;
    t_noise;
    t_overrun;
    t_irq;
    t_disable;
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule